// File: doc/BRIEF.md
# Three-Wire Addressed Control Receiver

This block accepts configuration for a dual-loop frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three pins are oversampled in the system clock domain through synchronizer chains. Each rising edge of the serial clock shifts one data bit into a 24-bit shift register, and a rising edge of the load strobe hands the whole register to a decoder as one control word.

Words identify themselves. A word whose top bit is set is the main-divider word. Otherwise a 3-bit address under the top bit selects the charge-pump word, the auxiliary word, the reference word or the test word. Only the holding register of the selected word is updated. An address that names no word changes nothing and raises a one-cycle error flag. The decoded fields (divide ratios, pump currents and polarities, reference selects, enables, speed-up duration and gains) drive the rest of the synthesizer. All holding registers clear to zero on reset, so both loops stay disabled until they are programmed.

Top module: `synth_ctrl_rx`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data bit in at bit 23 and moves the register one place toward bit 0, so after 24 edges the first bit sent sits in bit 0 and the last bit sent sits in bit 23.
- R2: A loaded word with bit 23 = 1 is the main word: main_div = bits 17:0, the low speed-up nibble spd_dur[3:0] = bits 21:18, spd_standby = bit 22.
- R3: Bit 23 = 0 and bits 22:20 = 000 select the pump word: chg_cur = bits 7:0, spd_dur[7:4] = bits 11:8, integ_gain = bits 15:12, boost_gain = bits 17:16, main_pol = bit 18, pd_mode = bit 19.
- R4: Bit 23 = 0 and bits 22:20 = 001 select the auxiliary word: aux_ratio = bits 11:0, aux_pre_bypass = bit 12 (0 means divide by 4, 1 means divide by 1), aux_pol = bit 13, aux_ref_sel = bits 15:14, aux_en = bit 16.
- R5: Bit 23 = 0 and bits 22:20 = 010 select the reference word: ref_ratio = bits 11:0, main_ref_sel = bits 13:12, main_en = bit 14.
- R6: Bit 23 = 0 and bits 22:20 = 111 select the test word: bits 10:0 are stored and presented on test_field and affect no other output.
- R7: Bit 23 = 0 with bits 22:20 equal to 011, 100, 101 or 110 leaves every output unchanged and drives addr_err high for exactly one system clock cycle.
- R8: A synchronous reset clears every output to zero, so main_en and aux_en are both off.
- R9: A load changes only the fields of the word it carries; the fields of the other words keep their values.
- R10: When a load-strobe rise and a serial-clock rise are detected in the same cycle, the word loaded is the register content before that shift, and the new bit stays in the register at bit 23.
- R11: Changes of the data pin while the serial clock stays high or low have no effect; only the value present at the rising edge is taken.
- R12: A load does not clear the shift register: a strobe after only K new bits loads the K new bits in the top K positions above the upper 24-K bits of the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on ser_clk rise |
| ser_load | input | 1 | Load strobe; rising edge transfers the shift register |
| main_div | output | 18 | Main divider ratio |
| chg_cur | output | 8 | Main charge-pump current factor |
| spd_dur | output | 8 | Speed-up duration in reference cycles (high and low nibble) |
| integ_gain | output | 4 | Integral pump acceleration factor |
| boost_gain | output | 2 | Main pump current boost during speed-up |
| main_pol | output | 1 | Main pump polarity |
| pd_mode | output | 1 | Phase detector reset-pulse mode |
| spd_standby | output | 1 | Speed-up pump standby control |
| aux_ratio | output | 12 | Auxiliary divider ratio |
| aux_pre_bypass | output | 1 | Auxiliary prescaler: 0 divide by 4, 1 divide by 1 |
| aux_pol | output | 1 | Auxiliary pump polarity |
| aux_ref_sel | output | 2 | Reference select for the auxiliary phase detector |
| aux_en | output | 1 | Auxiliary divider enable |
| ref_ratio | output | 12 | Reference divider ratio |
| main_ref_sel | output | 2 | Reference select for the main phase detector |
| main_en | output | 1 | Main divider enable |
| test_field | output | 11 | Stored test bits |
| addr_err | output | 1 | One-cycle pulse on an unassigned address |

## Verification
The shift and the load can fall in the same system cycle when the strobe and the serial clock rise together at the pins, which the bench provokes by raising both in one step after a full word has been shifted in. It is judged by checking that the outputs show the word shifted in before that edge, and that after 23 further bits and a second strobe the next word appears with the coincident bit as its bit 0. Both outcomes are predicted by a model of the word layout kept in the bench.

// File: rtl/synth_ctrl_pkg.sv
// Package: shared widths, address codes and word classification for the
// three-wire control receiver. Assumes a fixed 24-bit word format.
package synth_ctrl_pkg;

    localparam int WORD_W  = 24;
    localparam int TAG_BIT = 23;
    localparam int ADDR_HI = 22;
    localparam int ADDR_LO = 20;

    localparam logic [2:0] ADDR_PUMP = 3'b000;
    localparam logic [2:0] ADDR_AUX  = 3'b001;
    localparam logic [2:0] ADDR_REF  = 3'b010;
    localparam logic [2:0] ADDR_TEST = 3'b111;

    // Stored widths of each holding register (only bits that are used)
    localparam int MAIN_W = 23;
    localparam int PUMP_W = 20;
    localparam int AUX_W  = 17;
    localparam int REF_W  = 15;
    localparam int TEST_W = 11;

    // Field widths
    localparam int NDIV_W  = 18;
    localparam int CUR_W   = 8;
    localparam int NIB_W   = 4;
    localparam int GAIN_W  = 4;
    localparam int BOOST_W = 2;
    localparam int RATIO_W = 12;
    localparam int SEL_W   = 2;

    typedef enum logic [2:0] {
        TGT_MAIN,
        TGT_PUMP,
        TGT_AUX,
        TGT_REF,
        TGT_TEST,
        TGT_BAD
    } target_e;

    // Map a complete word to the register it addresses
    function automatic target_e classify(input logic [WORD_W-1:0] w);
        target_e t;
        if (w[TAG_BIT]) begin
            t = TGT_MAIN;
        end else begin
            unique case (w[ADDR_HI:ADDR_LO])
                ADDR_PUMP: t = TGT_PUMP;
                ADDR_AUX:  t = TGT_AUX;
                ADDR_REF:  t = TGT_REF;
                ADDR_TEST: t = TGT_TEST;
                default:   t = TGT_BAD;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/synth_pin_sync.sv
// Module: multi-flop synchronizer for one asynchronous input pin.
// Assumes the pin is stable for several system clock periods per level
// (serial interface at most a few MHz against a faster system clock).
module synth_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    logic [STAGES-1:0] chain;

    // Purpose: move the pin through STAGES flops into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_i};
    end

    assign level_o = chain[STAGES-1];

endmodule

// File: rtl/synth_shifter.sv
// Module: serial-in shift register, new bit entering at the top.
// Assumes shift_en is a single-cycle pulse per serial clock rise.
module synth_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);

    // Purpose: shift toward bit 0 so the first bit ends at the LSB
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (shift_en) word_o <= {bit_i, word_o[W-1:1]};
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word_o == {$past(bit_i), $past(word_o[W-1:1])});

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o));

endmodule

// File: rtl/synth_word_regs.sv
// Module: classifies a loaded word and updates exactly one holding register.
// Assumes load is a single-cycle pulse; word_i is the shift register content
// in the cycle of that pulse.
module synth_word_regs
    import synth_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_i,
    output logic [MAIN_W-1:0] reg_main,
    output logic [PUMP_W-1:0] reg_pump,
    output logic [AUX_W-1:0]  reg_aux,
    output logic [REF_W-1:0]  reg_ref,
    output logic [TEST_W-1:0] reg_test,
    output logic              addr_err
);

    target_e tgt;

    // Purpose: decode the destination of the current shift register content
    always_comb tgt = classify(word_i);

    // Purpose: write the addressed holding register on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_main <= '0;
            reg_pump <= '0;
            reg_aux  <= '0;
            reg_ref  <= '0;
            reg_test <= '0;
        end else if (load) begin
            unique case (tgt)
                TGT_MAIN: reg_main <= word_i[MAIN_W-1:0];
                TGT_PUMP: reg_pump <= word_i[PUMP_W-1:0];
                TGT_AUX:  reg_aux  <= word_i[AUX_W-1:0];
                TGT_REF:  reg_ref  <= word_i[REF_W-1:0];
                TGT_TEST: reg_test <= word_i[TEST_W-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: flag a load whose address names no register
    always_ff @(posedge clk) begin
        if (!rst_n) addr_err <= 1'b0;
        else        addr_err <= load && (tgt == TGT_BAD);
    end

    // R7
    no_update_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $stable(reg_main) && $stable(reg_pump) && $stable(reg_aux)
                     && $stable(reg_ref) && $stable(reg_test));

    // R7
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> !addr_err);

    // R9
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_main != $past(reg_main), reg_pump != $past(reg_pump),
                    reg_aux != $past(reg_aux), reg_ref != $past(reg_ref),
                    reg_test != $past(reg_test)}) <= 1);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(reg_main) && $stable(reg_pump) && $stable(reg_aux)
                  && $stable(reg_ref) && $stable(reg_test) && !addr_err);

endmodule

// File: rtl/synth_ctrl_rx.sv
// Module: top of the three-wire control receiver. Synchronizes the serial
// pins, detects clock and strobe rises, shifts data, and presents the
// decoded fields of the five holding registers.
// Assumes each serial pin level lasts at least SYNC_STAGES+1 system cycles.
module synth_ctrl_rx
    import synth_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_load,
    output logic [NDIV_W-1:0]  main_div,
    output logic [CUR_W-1:0]   chg_cur,
    output logic [2*NIB_W-1:0] spd_dur,
    output logic [GAIN_W-1:0]  integ_gain,
    output logic [BOOST_W-1:0] boost_gain,
    output logic               main_pol,
    output logic               pd_mode,
    output logic               spd_standby,
    output logic [RATIO_W-1:0] aux_ratio,
    output logic               aux_pre_bypass,
    output logic               aux_pol,
    output logic [SEL_W-1:0]   aux_ref_sel,
    output logic               aux_en,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic [SEL_W-1:0]   main_ref_sel,
    output logic               main_en,
    output logic [TEST_W-1:0]  test_field,
    output logic               addr_err
);

    localparam int NPINS  = 3;
    localparam int P_CLK  = 0;
    localparam int P_DATA = 1;
    localparam int P_LOAD = 2;

    logic [NPINS-1:0]  pins_raw;
    logic [NPINS-1:0]  pins_lvl;
    logic              clk_prev;
    logic              load_prev;
    logic              clk_rise;
    logic              load_rise;
    logic [WORD_W-1:0] shreg;
    logic [MAIN_W-1:0] reg_main;
    logic [PUMP_W-1:0] reg_pump;
    logic [AUX_W-1:0]  reg_aux;
    logic [REF_W-1:0]  reg_ref;
    logic [TEST_W-1:0] reg_test;

    assign pins_raw = {ser_load, ser_data, ser_clk};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        synth_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins_raw[g]),
            .level_o (pins_lvl[g])
        );
    end

    // Purpose: remember last synchronized clock and strobe levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev  <= 1'b0;
            load_prev <= 1'b0;
        end else begin
            clk_prev  <= pins_lvl[P_CLK];
            load_prev <= pins_lvl[P_LOAD];
        end
    end

    assign clk_rise  = pins_lvl[P_CLK]  & ~clk_prev;
    assign load_rise = pins_lvl[P_LOAD] & ~load_prev;

    synth_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (clk_rise),
        .bit_i    (pins_lvl[P_DATA]),
        .word_o   (shreg)
    );

    synth_word_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_rise),
        .word_i   (shreg),
        .reg_main (reg_main),
        .reg_pump (reg_pump),
        .reg_aux  (reg_aux),
        .reg_ref  (reg_ref),
        .reg_test (reg_test),
        .addr_err (addr_err)
    );

    // Field slicing: main word
    assign main_div       = reg_main[17:0];
    assign spd_dur[3:0]   = reg_main[21:18];
    assign spd_standby    = reg_main[22];
    // Field slicing: pump word
    assign chg_cur        = reg_pump[7:0];
    assign spd_dur[7:4]   = reg_pump[11:8];
    assign integ_gain     = reg_pump[15:12];
    assign boost_gain     = reg_pump[17:16];
    assign main_pol       = reg_pump[18];
    assign pd_mode        = reg_pump[19];
    // Field slicing: auxiliary word
    assign aux_ratio      = reg_aux[11:0];
    assign aux_pre_bypass = reg_aux[12];
    assign aux_pol        = reg_aux[13];
    assign aux_ref_sel    = reg_aux[15:14];
    assign aux_en         = reg_aux[16];
    // Field slicing: reference word
    assign ref_ratio      = reg_ref[11:0];
    assign main_ref_sel   = reg_ref[13:12];
    assign main_en        = reg_ref[14];
    // Test word
    assign test_field     = reg_test;

    // R1
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> !clk_rise);

    // R10
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_rise |=> !load_rise);

endmodule

// File: tb/synth_ctrl_rx_test.sv
module synth_ctrl_rx_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;

    logic [17:0] main_div;
    logic [7:0]  chg_cur;
    logic [7:0]  spd_dur;
    logic [3:0]  integ_gain;
    logic [1:0]  boost_gain;
    logic        main_pol, pd_mode, spd_standby;
    logic [11:0] aux_ratio;
    logic        aux_pre_bypass, aux_pol;
    logic [1:0]  aux_ref_sel;
    logic        aux_en;
    logic [11:0] ref_ratio;
    logic [1:0]  main_ref_sel;
    logic        main_en;
    logic [10:0] test_field;
    logic        addr_err;

    int n_chk = 0;
    int n_err = 0;
    int err_cnt = 0;

    always #10 clk = ~clk;

    synth_ctrl_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .main_div(main_div), .chg_cur(chg_cur),
        .spd_dur(spd_dur), .integ_gain(integ_gain), .boost_gain(boost_gain),
        .main_pol(main_pol), .pd_mode(pd_mode), .spd_standby(spd_standby),
        .aux_ratio(aux_ratio), .aux_pre_bypass(aux_pre_bypass),
        .aux_pol(aux_pol), .aux_ref_sel(aux_ref_sel), .aux_en(aux_en),
        .ref_ratio(ref_ratio), .main_ref_sel(main_ref_sel), .main_en(main_en),
        .test_field(test_field), .addr_err(addr_err)
    );

    // Count cycles with the error flag high, sampled away from the edge
    always @(negedge clk) if (addr_err) err_cnt++;

    // Bit 24 = expected error flag, bits 23:0 = word
    localparam int NV = 8;
    localparam logic [24:0] VECS [NV] = '{
        25'h0F2ABCD, 25'h00F5A3C, 25'h01ABCDE, 25'h02F7123,
        25'h07005A5, 25'h13FFFFF, 25'h1512345, 25'h0812345
    };

    // Expected state, built from the requirement layout
    logic [23:0] e_main, e_pump, e_aux, e_ref, e_test;

    task automatic model(input logic [23:0] w);
        if (w[23]) e_main = {1'b0, w[22:0]};
        else case (w[22:20])
            3'b000: e_pump = {4'b0, w[19:0]};
            3'b001: e_aux  = {7'b0, w[16:0]};
            3'b010: e_ref  = {9'b0, w[14:0]};
            3'b111: e_test = {13'b0, w[10:0]};
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({"R2 main_div ", ctx},    32'(main_div),    32'(e_main[17:0]));
        chk({"R2 spd_lo ", ctx},      32'(spd_dur[3:0]), 32'(e_main[21:18]));
        chk({"R2 standby ", ctx},     32'(spd_standby), 32'(e_main[22]));
        chk({"R3 pump ", ctx},
            32'({pd_mode, main_pol, boost_gain, integ_gain, spd_dur[7:4], chg_cur}),
            32'(e_pump[19:0]));
        chk({"R4 aux ", ctx},
            32'({aux_en, aux_ref_sel, aux_pol, aux_pre_bypass, aux_ratio}),
            32'(e_aux[16:0]));
        chk({"R5 ref ", ctx},
            32'({main_en, main_ref_sel, ref_ratio}), 32'(e_ref[14:0]));
        chk({"R6 test ", ctx},        32'(test_field),  32'(e_test[10:0]));
    endtask

    task automatic shift_bit(input logic b, input bit noisy);
        @(negedge clk);
        ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        if (noisy) begin
            @(negedge clk); ser_data = ~b;
            @(negedge clk); ser_data = b;
            @(negedge clk); ser_data = ~b;
        end else begin
            repeat (3) @(negedge clk);
        end
        ser_clk = 1'b0;
        if (noisy) begin
            @(negedge clk); ser_data = b;
        end
    endtask

    task automatic shift_bits(input logic [23:0] w, input int n, input bit noisy);
        for (int i = 0; i < n; i++) shift_bit(w[i], noisy);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        err_cnt = 0;
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        ser_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_all();
        logic [23:0] w;
        logic [23:0] prev;
        e_main = '0; e_pump = '0; e_aux = '0; e_ref = '0; e_test = '0;
        repeat (4) @(negedge clk);
        // R8: reset state
        compare_all("reset");
        chk("R8 addr_err at reset", 32'(addr_err), 32'd0);
        chk("R8 enables at reset", 32'({main_en, aux_en}), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        compare_all("after reset");

        // Vector table: R1..R7, R9
        for (int i = 0; i < NV; i++) begin
            w = VECS[i][23:0];
            shift_bits(w, 24, 1'b0);
            pulse_load();
            model(w);
            chk("R7 error pulse count", 32'(err_cnt), 32'(VECS[i][24]));
            compare_all("R9 vector");
        end

        // R10: strobe and serial clock rise together
        shift_bits(24'hA0F00F, 24, 1'b0);
        @(negedge clk);
        ser_data = 1'b0;                 // bit 0 of 24'h0C3C3C
        repeat (3) @(negedge clk);
        err_cnt = 0;
        ser_clk = 1'b1;
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        ser_load = 1'b0;
        repeat (4) @(negedge clk);
        model(24'hA0F00F);
        compare_all("R10 coincident load");
        shift_bits(24'h0C3C3C >> 1, 23, 1'b0);
        pulse_load();
        model(24'h0C3C3C);
        compare_all("R10 next word");
        prev = 24'h0C3C3C;

        // R12: partial word keeps upper bits of previous content
        shift_bits(24'h000005, 8, 1'b0);
        pulse_load();
        w = {8'h05, prev[23:8]};
        model(w);
        compare_all("R12 partial word");
        chk("R12 no error", 32'(err_cnt), 32'd0);

        // R11: data glitches while the serial clock is steady
        shift_bits(24'h7003C5, 24, 1'b1);
        pulse_load();
        model(24'h7003C5);
        compare_all("R11 noisy data");
        shift_bits(24'h9ABCDE, 24, 1'b1);
        pulse_load();
        model(24'h9ABCDE);
        compare_all("R11 noisy main word");

        // R8: reset after programming
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        e_main = '0; e_pump = '0; e_aux = '0; e_ref = '0; e_test = '0;
        compare_all("R8 reset again");
        chk("R8 enables cleared", 32'({main_en, aux_en}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog expired act=running exp=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule